// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This block is a passive monitor on the command bus of a four-bank synchronous DRAM. On every sampled clock edge it decodes the command lines and updates a state for each bank: idle, active with an open row, or active with a pending automatic close. For each bank it also counts the sampled cycles since that bank's most recent activate. The monitor never drives the memory bus.

A command that does not suit the addressed bank's state, or that arrives sooner than a minimum gap set by parameters in clock cycles, is a violation. The first violation is latched as a flag, a three-bit code and a bank number. These hold until `clr_i` is pulsed. The open/closed status and the open row of each bank are also visible at the ports, so a bench or a system checker can follow bank occupancy.

The monitor honours clock-enable gating. When clock enable is low at one edge, the monitor ignores the bus at the next edge, and all of its counters hold for that edge.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Activate ({ras_ni,cas_ni,we_ni}=011) on an idle bank opens it and stores `addr_i[ROW_W-1:0]` as its row. Activate on a bank that is already open, including one waiting for automatic close, raises code 1 and changes nothing.
- R2: Read (101) or write (100) on a bank that is not plainly active (idle, or waiting for automatic close) raises code 2 and has no effect.
- R3: Precharge (010) closes the bank chosen by `ba_i`. With `addr_i[10]` high it closes every bank. Precharge of an idle bank is legal.
- R4: A read or write with `addr_i[10]` high leaves the bank open for exactly BURST_LEN further sampled edges. The bank is idle after the BURST_LEN-th edge.
- R5: Refresh (001) closes all banks. If any bank is open when refresh is issued, the monitor raises code 6.
- R6: When `cs_ni` is high, the monitor decodes no command. Any encoding other than the five above is also treated as no command.
- R7: If `cke_i` is low at edge k, the monitor ignores the bus at edge k+1. At that edge no bank state, row, activate counter or close countdown changes.
- R8: A read or write to an active bank that arrives fewer than T_RCD sampled edges after that bank's activate raises code 3. The command still takes effect.
- R9: A precharge that closes an active bank fewer than T_RAS sampled edges after its activate raises code 4.
- R10: An activate on an idle bank that arrives fewer than T_RC sampled edges after the same bank's previous activate raises code 5. The bank still opens.
- R11: `err_o` holds the first violation's code and bank until `clr_i` is high at an edge. If a new violation arrives at the same edge as the clear, the new violation is captured.
- R12: When one edge produces violations on several banks (precharge-all or refresh), the lowest-numbered violating bank and its code are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the bus is sampled on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable of the memory bus |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | $clog2(NUM_BANKS) | Bank select |
| addr_i | input | ADDR_W | Address; bit 10 selects auto close / all banks |
| clr_i | input | 1 | Clears the latched violation |
| bank_open_o | output | NUM_BANKS | One bit per bank, high while open |
| bank_row_o | output | NUM_BANKS*ROW_W | Open row of each bank, bank 0 in the low bits |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of the latched violation |
| err_bank_o | output | $clog2(NUM_BANKS) | Bank of the latched violation |

## Verification
On every cycle, the assertions check the local rules: an activate opens an idle bank with the driven row, and precharge and refresh close banks. They also check that a read or write on a closed bank is flagged, that an unsampled edge leaves banks unchanged, and that a latched error holds until cleared. The bench's scenarios are what show the minimum-gap violations at the exact edge counts, and the countdown length of the automatic close. They also cover lowest-bank selection when several banks violate, clear and capture at the same edge, and the masking by chip select and clock enable. These are compared against a bench model over a long random command stream.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_ACT_OPEN  = 3'd1,
    ERR_RW_CLOSED = 3'd2,
    ERR_RCD       = 3'd3,
    ERR_RAS       = 3'd4,
    ERR_RC        = 3'd5,
    ERR_REF_OPEN  = 3'd6
  } err_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_ACTIVE, BK_AP_PEND
  } bank_st_e;
endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
  import sbm_pkg::*;
(
  input  logic sample_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (sample_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sbm_bank.sv
module sbm_bank
  import sbm_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  cmd_e             cmd_i,
  input  logic             hit_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output err_e             err_o
);
  localparam int T_MAX = (T_RC > T_RAS) ? ((T_RC > T_RCD) ? T_RC : T_RCD)
                                        : ((T_RAS > T_RCD) ? T_RAS : T_RCD);
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;
  localparam int AP_W  = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] RCD_C = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RAS_C = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] RC_C  = CNT_W'(T_RC);
  localparam logic [AP_W-1:0]  BL_C  = AP_W'(BURST_LEN);

  bank_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AP_W-1:0]  apc_q, apc_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    apc_d   = apc_q;
    row_d   = row_q;
    err_o   = ERR_NONE;
    if (sample_i) begin
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      // auto close countdown; a command below may override it
      if (state_q == BK_AP_PEND) begin
        if (apc_q <= AP_W'(1)) state_d = BK_IDLE;
        else                   apc_d   = apc_q - 1'b1;
      end
      unique case (cmd_i)
        CMD_ACT: if (hit_i) begin
          if (state_q != BK_IDLE) err_o = ERR_ACT_OPEN;
          else begin
            if (cnt_q < RC_C) err_o = ERR_RC;
            state_d = BK_ACTIVE;
            row_d   = row_i;
            cnt_d   = CNT_W'(1);
          end
        end
        CMD_RD, CMD_WR: if (hit_i) begin
          if (state_q != BK_ACTIVE) err_o = ERR_RW_CLOSED;
          else begin
            if (cnt_q < RCD_C) err_o = ERR_RCD;
            if (ap_i) begin
              state_d = BK_AP_PEND;
              apc_d   = BL_C;
            end
          end
        end
        CMD_PRE: if (hit_i || ap_i) begin
          if (state_q == BK_ACTIVE && cnt_q < RAS_C) err_o = ERR_RAS;
          state_d = BK_IDLE;
        end
        CMD_REF: begin
          if (state_q != BK_IDLE) err_o = ERR_REF_OPEN;
          state_d = BK_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_IDLE;
      cnt_q   <= '1;
      apc_q   <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      apc_q   <= apc_d;
      row_q   <= row_d;
    end
  end

  assign open_o = (state_q != BK_IDLE);
  assign row_o  = row_q;

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && cmd_i == CMD_ACT && hit_i && !open_o |=> open_o && row_o == $past(row_i)); // R1
  AST_RW_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && (cmd_i == CMD_RD || cmd_i == CMD_WR) && hit_i && !open_o |-> err_o == ERR_RW_CLOSED); // R2
  AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && cmd_i == CMD_PRE && (hit_i || ap_i) |=> !open_o); // R3
  AST_REF_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && cmd_i == CMD_REF |=> !open_o); // R5
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(open_o) && $stable(row_o)); // R7
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sbm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cke_i,
  input  logic                          cs_ni,
  input  logic                          ras_ni,
  input  logic                          cas_ni,
  input  logic                          we_ni,
  input  logic [$clog2(NUM_BANKS)-1:0]  ba_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          clr_i,
  output logic [NUM_BANKS-1:0]          bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0]    bank_row_o,
  output logic                          err_o,
  output logic [2:0]                    err_code_o,
  output logic [$clog2(NUM_BANKS)-1:0]  err_bank_o
);
  localparam int BA_W = $clog2(NUM_BANKS);

  logic            sample_q;
  cmd_e            cmd;
  err_e            bank_err [NUM_BANKS];
  err_e            sel_code;
  logic [BA_W-1:0] sel_bank;
  logic            any_viol;
  logic            err_q;
  err_e            code_q;
  logic [BA_W-1:0] bank_q;

  // cke low at one edge masks the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= 1'b1;
    else         sample_q <= cke_i;
  end

  sbm_cmd_decode i_decode (
    .sample_i (sample_q),
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .cmd_o    (cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sbm_bank #(
      .ROW_W     (ROW_W),
      .T_RCD     (T_RCD),
      .T_RAS     (T_RAS),
      .T_RC      (T_RC),
      .BURST_LEN (BURST_LEN)
    ) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sample_q),
      .cmd_i    (cmd),
      .hit_i    (ba_i == BA_W'(g)),
      .ap_i     (addr_i[AP_BIT]),
      .row_i    (addr_i[ROW_W-1:0]),
      .open_o   (bank_open_o[g]),
      .row_o    (bank_row_o[g*ROW_W +: ROW_W]),
      .err_o    (bank_err[g])
    );
  end

  // lowest violating bank wins
  always_comb begin
    sel_code = ERR_NONE;
    sel_bank = '0;
    any_viol = 1'b0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bank_err[b] != ERR_NONE) begin
        sel_code = bank_err[b];
        sel_bank = BA_W'(b);
        any_viol = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
      bank_q <= '0;
    end else if (any_viol && (clr_i || !err_q)) begin
      err_q  <= 1'b1;
      code_q <= sel_code;
      bank_q <= sel_bank;
    end else if (clr_i) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
      bank_q <= '0;
    end
  end

  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign err_bank_o = bank_q;

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o && $stable(err_code_o) && $stable(err_bank_o)); // R11
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !any_viol |=> !err_o); // R11
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_q && !clr_i |=> $stable(err_o) && $stable(bank_open_o)); // R7
endmodule

// File: tb/test_sdram_bank_monitor.sv
module test_sdram_bank_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, T_RCD = 3, T_RAS = 6, T_RC = 9, BL = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, clr_i = 1'b0;
  logic [1:0]  ba_i = '0;
  logic [11:0] addr_i = '0;
  logic [NB-1:0]    bank_open_o;
  logic [NB*12-1:0] bank_row_o;
  logic        err_o;
  logic [2:0]  err_code_o;
  logic [1:0]  err_bank_o;

  int checks = 0, fails = 0;
  int m_st [NB], m_cnt [NB], m_apc [NB], m_row [NB];
  bit m_ckeq = 1'b1, m_err = 1'b0;
  int m_code = 0, m_bank = 0;

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bank_monitor #(.NUM_BANKS(NB), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
                       .BURST_LEN(BL)) i_sdram_bank_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .addr_i(addr_i), .clr_i(clr_i),
    .bank_open_o(bank_open_o), .bank_row_o(bank_row_o), .err_o(err_o),
    .err_code_o(err_code_o), .err_bank_o(err_bank_o));

  function automatic int decode(input logic [2:0] rcw);
    case (rcw)
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [NB-1:0] m_open();
    logic [NB-1:0] v;
    for (int b = 0; b < NB; b++) v[b] = (m_st[b] != 0);
    return v;
  endfunction

  task automatic model_step();
    int vc [NB];
    int nv_b, cmd, ns, ncnt;
    bit samp, hit, ap;
    samp = m_ckeq;
    m_ckeq = cke_i;
    nv_b = -1;
    for (int b = 0; b < NB; b++) vc[b] = 0;
    if (samp) begin
      cmd = cs_ni ? 0 : decode({ras_ni, cas_ni, we_ni});
      ap = addr_i[10];
      for (int b = 0; b < NB; b++) begin
        hit = (int'(ba_i) == b);
        ns = m_st[b];
        ncnt = (m_cnt[b] < 1000) ? m_cnt[b] + 1 : 1000;
        if (m_st[b] == 2) begin
          if (m_apc[b] <= 1) ns = 0;
          else m_apc[b]--;
        end
        case (cmd)
          1: if (hit) begin
            if (m_st[b] != 0) vc[b] = 1;
            else begin
              if (m_cnt[b] < T_RC) vc[b] = 5;
              ns = 1; m_row[b] = int'(addr_i); ncnt = 1;
            end
          end
          2, 3: if (hit) begin
            if (m_st[b] != 1) vc[b] = 2;
            else begin
              if (m_cnt[b] < T_RCD) vc[b] = 3;
              if (ap) begin ns = 2; m_apc[b] = BL; end
            end
          end
          4: if (hit || ap) begin
            if (m_st[b] == 1 && m_cnt[b] < T_RAS) vc[b] = 4;
            ns = 0;
          end
          5: begin
            if (m_st[b] != 0) vc[b] = 6;
            ns = 0;
          end
          default: ;
        endcase
        m_st[b] = ns;
        m_cnt[b] = ncnt;
      end
      for (int b = NB - 1; b >= 0; b--) if (vc[b] != 0) nv_b = b;
    end
    if (nv_b >= 0 && (clr_i || !m_err)) begin
      m_err = 1'b1; m_code = vc[nv_b]; m_bank = nv_b;
    end else if (clr_i) begin
      m_err = 1'b0; m_code = 0; m_bank = 0;
    end
  endtask

  task automatic compare(input string tag);
    bit ok;
    ok = (bank_open_o == m_open()) && (err_o == m_err);
    if (m_err) ok = ok && (int'(err_code_o) == m_code) && (int'(err_bank_o) == m_bank);
    for (int b = 0; b < NB; b++)
      if (m_st[b] != 0 && int'(bank_row_o[b*12 +: 12]) != m_row[b]) ok = 1'b0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: open=%b err=%b code=%0d bank=%0d expected open=%b err=%b code=%0d bank=%0d",
               tag, bank_open_o, err_o, err_code_o, err_bank_o, m_open(), m_err, m_code, m_bank);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] rcw, input int ba, input logic [11:0] addr,
                      input logic cs_n, input logic cke, input logic clr, input string tag);
    cs_ni = cs_n; {ras_ni, cas_ni, we_ni} = rcw; ba_i = 2'(ba); addr_i = addr;
    cke_i = cke; clr_i = clr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cmd(input logic [2:0] rcw, input int ba, input logic [11:0] addr, input string tag);
    step(rcw, ba, addr, 1'b0, 1'b1, 1'b0, tag);
  endtask

  task automatic nop(input int n, input string tag);
    for (int i = 0; i < n; i++) step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin
      m_st[b] = 0; m_cnt[b] = 1000; m_apc[b] = 0; m_row[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    compare("reset");
    chk("reset open", int'(bank_open_o), 0);

    // R1 activate, R8 early read
    cmd(C_ACT, 0, 12'h123, "R1 act");
    chk("R1 open", int'(bank_open_o), 1);
    chk("R1 row", int'(bank_row_o[11:0]), 'h123);
    nop(1, "R8 gap");
    cmd(C_RD, 0, 12'h000, "R8 early read");
    chk("R8 code", int'(err_code_o), 3);
    step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear");
    chk("R11 cleared", int'(err_o), 0);
    // R1 act on open bank, then R11 clear with simultaneous R2 violation
    cmd(C_ACT, 0, 12'h055, "R1 act on open");
    chk("R1 act open code", int'(err_code_o), 1);
    chk("R1 row kept", int'(bank_row_o[11:0]), 'h123);
    step(C_RD, 2, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear+capture");
    chk("R2 code", int'(err_code_o), 2);
    chk("R11 bank", int'(err_bank_o), 2);
    step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear");
    // R9 early precharge, R10 early re-activate
    cmd(C_ACT, 1, 12'h0aa, "R9 act");
    nop(2, "R9 gap");
    cmd(C_PRE, 1, 12'h000, "R9 early pre");
    chk("R9 code", int'(err_code_o), 4);
    chk("R9 bank", int'(err_bank_o), 1);
    step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear");
    cmd(C_ACT, 1, 12'h0bb, "R10 early act");
    chk("R10 code", int'(err_code_o), 5);
    chk("R10 opened", int'(bank_open_o[1]), 1);
    step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear");
    // R4 write with auto close
    nop(10, "R4 gap");
    cmd(C_WR, 1, 12'h400, "R4 write ap");
    chk("R4 err", int'(err_o), 0);
    for (int i = 0; i < BL - 1; i++) begin
      nop(1, "R4 count");
      chk("R4 still open", int'(bank_open_o[1]), 1);
    end
    nop(1, "R4 close");
    chk("R4 closed", int'(bank_open_o[1]), 0);
    // R7 masked edge
    step(C_ACT, 2, 12'h0cc, 1'b0, 1'b0, 1'b0, "R7 act cke low");
    step(C_PRE, 2, 12'h000, 1'b0, 1'b1, 1'b0, "R7 masked pre");
    chk("R7 still open", int'(bank_open_o[2]), 1);
    // R6 deselected precharge-all
    step(C_PRE, 0, 12'h400, 1'b1, 1'b1, 1'b0, "R6 cs high");
    chk("R6 open", int'(bank_open_o), 'b0101);
    // R5 refresh with open banks, R12 lowest bank
    cmd(C_REF, 3, 12'h000, "R5 ref");
    chk("R5 code", int'(err_code_o), 6);
    chk("R12 ref bank", int'(err_bank_o), 0);
    chk("R5 all closed", int'(bank_open_o), 0);
    step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear");
    // R3 precharge single, all, idle
    cmd(C_ACT, 0, 12'h011, "R3 act");
    cmd(C_ACT, 3, 12'h033, "R3 act");
    nop(8, "R3 gap");
    cmd(C_PRE, 0, 12'h000, "R3 pre one");
    chk("R3 one closed", int'(bank_open_o), 'b1000);
    cmd(C_PRE, 1, 12'h400, "R3 pre all");
    chk("R3 all closed", int'(bank_open_o), 0);
    cmd(C_PRE, 1, 12'h000, "R3 pre idle");
    chk("R3 no err", int'(err_o), 0);
    // R12 precharge-all with two violating banks
    cmd(C_ACT, 1, 12'h101, "R12 act");
    cmd(C_ACT, 2, 12'h202, "R12 act");
    cmd(C_PRE, 0, 12'h400, "R12 pre all");
    chk("R12 code", int'(err_code_o), 4);
    chk("R12 bank", int'(err_bank_o), 1);
    step(C_NOP, 0, 12'h0, 1'b0, 1'b1, 1'b1, "R11 clear");

    // random phase against the bench model
    for (int i = 0; i < 3000; i++) begin
      int r, k;
      logic [2:0] rcw;
      r = int'($urandom % 100);
      k = int'($urandom % 6);
      case (k)
        0: rcw = C_ACT; 1: rcw = C_RD; 2: rcw = C_WR;
        3: rcw = C_PRE; 4: rcw = (r < 30) ? C_REF : C_NOP;
        default: rcw = C_NOP;
      endcase
      step(rcw, int'($urandom % NB), 12'($urandom) & ((r % 3 == 0) ? 12'hfff : 12'hbff),
           (r < 8), !(r >= 90), ($urandom % 20 == 0), "random");
    end

    summary();
    $finish;
  end
endmodule